// File: doc/BRIEF.md
# Timebase Source and Timestamp Sync Arbiter

This block sits in a master trigger. It decides whether the board runs from its own internal timebase or from the timebase recovered on link L, the one link that can carry a clock in from another master. Software asks for the link source with a select bit. The block grants that request only after the link L deserializer has reported lock for a qualification window of consecutive cycles. It drops back to the internal source on its own whenever lock disappears, whatever software has selected. Each such drop sets a sticky status flag, and software clears the flag with a write strobe. The analog clock multiplexer is not part of the block. It is driven by the `use_link_o` select output.

The block also decides who may reset the timestamp. A remote timestamp-reset command is honoured only when both configuration conditions hold: link L is set to the remote-master data format, and bit 0 of the link L propagation control register is set. In that state, local reset requests are blocked. If either condition is false, remote commands are ignored and local requests work, even while the board runs from the recovered clock. Each request is edge-detected and gives exactly one pulse. That pulse clears the timestamp counter inside the block.

Top module: `tsync_arbiter`

## Requirements
- R1: After reset `use_link_o`=0, `fallback_o`=0 and `sync_pulse_o`=0. The timestamp reads 1 after the first clock edge following reset release and then rises by 1 on every edge.
- R2: With `sel_link_i`=1, a lock that is newly high is qualified only after LOCK_CYCLES (default 256) consecutive edges with lock high. `use_link_o` goes to 1 after edge LOCK_CYCLES+1 and not earlier.
- R3: An edge that samples `link_lock_i`=0 makes `use_link_o`=0 after that edge, whatever the select bit. It also restarts the lock qualification from zero.
- R4: While `sel_link_i`=0, `use_link_o` stays 0 even with a long-qualified lock. With lock already qualified, setting the select bit gives `use_link_o`=1 after one edge.
- R5: `fallback_o` is set when an edge samples lock low while `use_link_o`=1. It stays set until an edge samples `fallback_clr_i`=1. If setting and clearing fall on the same edge, setting wins.
- R6: When `link_fmt_remote_i`=1 and `prop_l_bit0_i`=1, each rising edge of `remote_sync_i` gives one `sync_pulse_o` cycle after the next clock edge. Rising edges of `local_sync_i` give none.
- R7: When either of those two inputs is 0, `remote_sync_i` gives no pulse. Each rising edge of `local_sync_i` gives one pulse, whether `use_link_o` is 0 or 1.
- R8: A request input held high for several cycles gives exactly one pulse.
- R9: The cycle after `sync_pulse_o`=1, the timestamp reads 0. It then resumes counting by 1 per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_link_i | input | 1 | Software request to use the link L timebase |
| link_lock_i | input | 1 | Lock indication from the link L deserializer |
| link_fmt_remote_i | input | 1 | 1 = link L configured for remote-master format |
| prop_l_bit0_i | input | 1 | Bit 0 of the link L propagation control register |
| local_sync_i | input | 1 | Local timestamp-reset request (level, edge-detected) |
| remote_sync_i | input | 1 | Decoded remote timestamp-reset command (level, edge-detected) |
| fallback_clr_i | input | 1 | Write strobe clearing the fallback flag |
| use_link_o | output | 1 | Source select: 1 = link L timebase, 0 = internal |
| fallback_o | output | 1 | Sticky flag: lock was lost while on the link source |
| sync_pulse_o | output | 1 | One-cycle timestamp-reset pulse |
| timestamp_o | output | TS_W | Timestamp counter value |

## Verification
Sync arbitration is swept over all four combinations of the format and propagation bits. Each combination gets local and remote requests, both as one-cycle and as multi-cycle levels, and with both the link and the internal source active. This separates a design that gates on one condition from one that needs both, and separates edge detection from level detection. Source selection is tried with the select bit off under qualified lock, with a lock dropout partway through qualification, and with a lock loss while on the link source. These cases show whether the window restarts and whether the fallback overrides software. The flag is tried with a lone clear and with a clear on the same edge as a new loss, which exposes the set/clear priority.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_LINK     = 1'b1
    } src_e;

    // Remote sync takes over only when both configuration conditions hold.
    function automatic logic remote_owns_sync(input logic fmt_remote, input logic prop_bit0);
        return fmt_remote & prop_bit0;
    endfunction

endpackage

// File: rtl/tsync_lock_qual.sv
module tsync_lock_qual #(
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    output logic qual_o
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!lock_i) begin
            st_d.cnt = '0;
            st_d.ok  = 1'b0;
        end else if (st_q.cnt == CW'(LOCK_CYCLES - 1)) begin
            st_d.ok = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_o = st_q.ok;

    // R3: a missing lock restarts qualification
    p_lock_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> (!st_q.ok && st_q.cnt == '0));

    // R2: qualification only completes at the end of the window
    p_qual_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ok) |-> ($past(st_q.cnt) == CW'(LOCK_CYCLES - 1)));

endmodule

// File: rtl/tsync_src_sel.sv
module tsync_src_sel
    import tsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic lock_i,
    input  logic qual_i,
    input  logic fb_clr_i,
    output src_e src_o,
    output logic fallback_o
);
    typedef struct packed {
        src_e src;
        logic fb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.src = (sel_i && lock_i && qual_i) ? SRC_LINK : SRC_INTERNAL;
        if (st_q.src == SRC_LINK && !lock_i) st_d.fb = 1'b1;
        else if (fb_clr_i)                   st_d.fb = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src <= SRC_INTERNAL;
            st_q.fb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o      = st_q.src;
    assign fallback_o = st_q.fb;

    p_no_link_without_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> (st_q.src == SRC_INTERNAL));

    p_sel_off_internal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (st_q.src == SRC_INTERNAL));

    p_fallback_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fb && !fb_clr_i) |=> st_q.fb);

    p_fallback_on_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.src == SRC_LINK && !lock_i) |=> st_q.fb);

endmodule

// File: rtl/tsync_sync_arb.sv
module tsync_sync_arb
    import tsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_remote_i,
    input  logic prop_bit0_i,
    input  logic local_i,
    input  logic remote_i,
    output logic pulse_o
);
    typedef struct packed {
        logic loc_prev;
        logic rem_prev;
        logic pulse;
    } st_t;

    st_t  st_d, st_q;
    logic remote_mode;
    logic loc_rise, rem_rise;

    always_comb begin
        remote_mode   = remote_owns_sync(fmt_remote_i, prop_bit0_i);
        loc_rise      = local_i  & ~st_q.loc_prev;
        rem_rise      = remote_i & ~st_q.rem_prev;
        st_d.loc_prev = local_i;
        st_d.rem_prev = remote_i;
        st_d.pulse    = remote_mode ? rem_rise : loc_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R6: under remote ownership, local requests never produce a pulse
    p_local_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_remote_i && prop_bit0_i && !remote_i) |=> !st_q.pulse);

    // R7: otherwise the remote command is ignored
    p_remote_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fmt_remote_i && prop_bit0_i) && !local_i) |=> !st_q.pulse);

endmodule

// File: rtl/tsync_ts_counter.sv
module tsync_ts_counter #(
    parameter int TS_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    output logic [TS_W-1:0] ts_o
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = clear_i ? '0 : ts_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign ts_o = ts_q;

    p_clear_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ts_q == '0));

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (ts_q == TS_W'($past(ts_q) + 1'b1)));

endmodule

// File: rtl/tsync_arbiter.sv
module tsync_arbiter
    import tsync_pkg::*;
#(
    parameter int LOCK_CYCLES = 256,
    parameter int TS_W        = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_link_i,
    input  logic            link_lock_i,
    input  logic            link_fmt_remote_i,
    input  logic            prop_l_bit0_i,
    input  logic            local_sync_i,
    input  logic            remote_sync_i,
    input  logic            fallback_clr_i,
    output logic            use_link_o,
    output logic            fallback_o,
    output logic            sync_pulse_o,
    output logic [TS_W-1:0] timestamp_o
);
    logic lock_ok;
    src_e src;
    logic sync_pulse;

    tsync_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (link_lock_i),
        .qual_o (lock_ok)
    );

    tsync_src_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_link_i),
        .lock_i     (link_lock_i),
        .qual_i     (lock_ok),
        .fb_clr_i   (fallback_clr_i),
        .src_o      (src),
        .fallback_o (fallback_o)
    );

    tsync_sync_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .fmt_remote_i (link_fmt_remote_i),
        .prop_bit0_i  (prop_l_bit0_i),
        .local_i      (local_sync_i),
        .remote_i     (remote_sync_i),
        .pulse_o      (sync_pulse)
    );

    tsync_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sync_pulse),
        .ts_o    (timestamp_o)
    );

    assign use_link_o   = (src == SRC_LINK);
    assign sync_pulse_o = sync_pulse;

    // R2: the link source is only ever entered with lock present
    p_enter_link_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_link_o) |-> $past(link_lock_i) && $past(sel_link_i));

endmodule

// File: tb/tsync_arbiter_tb_top.sv
module tsync_arbiter_tb_top;
    localparam int LOCK_CYCLES = 256;
    localparam int TS_W        = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_link_i = 1'b0, link_lock_i = 1'b0, link_fmt_remote_i = 1'b0, prop_l_bit0_i = 1'b0;
    logic local_sync_i = 1'b0, remote_sync_i = 1'b0, fallback_clr_i = 1'b0;
    logic use_link_o, fallback_o, sync_pulse_o;
    logic [TS_W-1:0] timestamp_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tsync_arbiter #(.LOCK_CYCLES(LOCK_CYCLES), .TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_link_i(sel_link_i), .link_lock_i(link_lock_i),
        .link_fmt_remote_i(link_fmt_remote_i), .prop_l_bit0_i(prop_l_bit0_i),
        .local_sync_i(local_sync_i), .remote_sync_i(remote_sync_i),
        .fallback_clr_i(fallback_clr_i), .use_link_o(use_link_o), .fallback_o(fallback_o),
        .sync_pulse_o(sync_pulse_o), .timestamp_o(timestamp_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Lock is driven high and held; returns after use_link_o is expected high.
    task automatic qualify(input string req);
        link_lock_i = 1'b1;
        edges(LOCK_CYCLES);
        check({req, " use_link before window end"}, use_link_o, 0);
        edges(1);
        check({req, " use_link after window"}, use_link_o, 1);
    endtask

    task automatic run_sync(input bit use_remote, input int hold, input int exp, input string req);
        int  n = 0;
        bit  prev_pulse = 1'b0;
        if (use_remote) remote_sync_i = 1'b1;
        else            local_sync_i  = 1'b1;
        for (int i = 0; i < hold + 4; i++) begin
            @(negedge clk);
            if (prev_pulse) check("R9 timestamp after pulse", timestamp_o, 0);
            prev_pulse = sync_pulse_o;
            if (sync_pulse_o) n++;
            if (i == hold - 1) begin
                remote_sync_i = 1'b0;
                local_sync_i  = 1'b0;
            end
        end
        check(req, n, exp);
    endtask

    initial begin
        longint t0;
        edges(3);
        check("R1 use_link in reset", use_link_o, 0);
        check("R1 fallback in reset", fallback_o, 0);
        check("R1 sync in reset", sync_pulse_o, 0);
        rst_n = 1'b1;
        edges(1);
        check("R1 timestamp first edge", timestamp_o, 1);
        edges(5);
        check("R1 timestamp counting", timestamp_o, 6);

        // R4: lock qualified but select off
        link_lock_i = 1'b1;
        edges(LOCK_CYCLES + 20);
        check("R4 select off keeps internal", use_link_o, 0);
        sel_link_i = 1'b1;
        edges(1);
        check("R4 select on with qualified lock", use_link_o, 1);

        // R3/R5: lock loss while on link
        link_lock_i = 1'b0;
        edges(1);
        check("R3 fallback to internal", use_link_o, 0);
        check("R5 fallback flag set", fallback_o, 1);

        // R3: dropout partway restarts the window
        link_lock_i = 1'b1;
        edges(100);
        link_lock_i = 1'b0;
        edges(1);
        check("R3 still internal", use_link_o, 0);
        qualify("R2/R3 restart");
        check("R5 flag held across relock", fallback_o, 1);

        fallback_clr_i = 1'b1;
        edges(1);
        fallback_clr_i = 1'b0;
        check("R5 flag cleared", fallback_o, 0);

        // R5: set wins over clear on the same edge
        link_lock_i = 1'b0;
        fallback_clr_i = 1'b1;
        edges(1);
        fallback_clr_i = 1'b0;
        check("R5 set beats clear", fallback_o, 1);
        edges(2);
        check("R5 still set", fallback_o, 1);
        qualify("R2 requalify");

        // R6/R7/R8: sweep configuration, source and hold length, on both timebases
        for (int s = 0; s < 2; s++) begin
            if (s == 1) begin
                sel_link_i = 1'b0;
                edges(1);
                check("R7 internal source for sweep", use_link_o, 0);
            end
            for (int cfg = 0; cfg < 4; cfg++) begin
                bit honour;
                prop_l_bit0_i     = cfg[0];
                link_fmt_remote_i = cfg[1];
                honour = cfg[0] & cfg[1];
                edges(1);
                for (int src = 0; src < 2; src++) begin
                    for (int h = 1; h <= 3; h += 2) begin
                        int exp;
                        exp = ((src == 1) == honour) ? 1 : 0;
                        run_sync(src[0], h, exp,
                                 honour ? (h > 1 ? "R6/R8 remote-owned pulse count" : "R6 remote-owned pulse count")
                                        : (h > 1 ? "R7/R8 local-owned pulse count" : "R7 local-owned pulse count"));
                    end
                end
            end
        end

        // R9: counting resumes after a pulse
        prop_l_bit0_i = 1'b0;
        run_sync(1'b0, 1, 1, "R9 single pulse");
        t0 = timestamp_o;
        edges(7);
        check("R9 counting resumes", timestamp_o, t0 + 7);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule